// File: doc/BRIEF.md
# Ganged Row Counter Tracker

This block counts row activations for hammer protection in a memory controller with far less counter storage than one counter per row. A single counter stands for a gang of rows, one row taken from each bank. Rows join a gang through a per-bank scrambling key: the row address XOR the bank's key gives the gang number. An all-bank targeted refresh can then clean up after the whole gang in one command. Rows at the same address in different banks land in different gangs, so a sweep across banks does not pile up on one hot counter.

Each activation bumps its gang's counter. When the counter reaches the threshold, the block offers one mitigation request on a valid/ready port. The request carries the gang number and, for every bank, the row to protect (the gang number XOR that bank's key). The counter clears when the request is taken. Accepted gangs go into a short recent list, and a gang that reaches the threshold again while it is listed is dropped with its count cleared. List entries expire after a set number of refresh-interval ticks. The keys are written at boot and freeze at the first activation.

Top module: `rg_gang_tracker`

## Requirements
- R1: After reset `mit_valid` is 0, every gang counter is 0, the recent list is empty and the keys are 0.
- R2: An activation on bank b, row r counts toward gang r XOR key[b], so rows from different banks that map to the same gang share one counter.
- R3: Each activation raises its gang's counter by one, saturating at THRESH (default 250; 500 also supported). If the counter reaches THRESH while no request is held and the gang is not in the recent list, `mit_valid` is 1 with `mit_gang` equal to that gang from the clock edge that takes the THRESH-th activation.
- R4: While `mit_valid` is 1, bits [b*ROW_W +: ROW_W] of `mit_rows` equal `mit_gang` XOR key[b] for every bank b.
- R5: A held request keeps `mit_valid` and `mit_gang` unchanged until a cycle with `mit_ready` at 1. That cycle is the acceptance, and `mit_valid` drops after it unless a new trigger occurs.
- R6: On acceptance the gang's counter returns to 0. An activation of that same gang in the acceptance cycle leaves the counter at 1.
- R7: A gang that reaches THRESH while another request is held keeps its counter at THRESH and raises no request. Its next activation after the held request is accepted raises the request.
- R8: Accepted gangs enter the recent list. A listed gang that reaches THRESH raises no request, and its counter restarts from 0.
- R9: A list entry is removed on the RQ_WINDOW-th refresh tick after it entered (default 2). The list holds RQ_DEPTH gangs (default 4), and when it is full a new gang pushes out the oldest one.
- R10: A key write (`key_we`, `key_bank`, `key_val`) takes effect only before the first activation and only in a cycle without an activation. Later writes leave the keys, and hence `mit_rows`, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_we | input | 1 | Write a bank scrambling key |
| key_bank | input | BANK_W | Bank whose key is written |
| key_val | input | ROW_W | Key value |
| act_valid | input | 1 | A row activation occurs this cycle |
| act_bank | input | BANK_W | Bank of the activation |
| act_row | input | ROW_W | Row of the activation |
| refi_tick | input | 1 | One refresh interval has elapsed |
| mit_valid | output | 1 | Mitigation request held |
| mit_ready | input | 1 | Consumer takes the request |
| mit_gang | output | ROW_W | Gang number of the request |
| mit_rows | output | NUM_BANKS*ROW_W | Row to protect in each bank, bank 0 lowest |

## Verification
A corrupted counter shows at the ports as a request that comes early, late or never. The bench's model predicts the exact activation on which `mit_valid` must rise, so a count that is off by one shows up on that same clock edge. A bad key or a stale recent-list entry shows as wrong per-bank rows on the first request, or as a missing or extra request on the first threshold crossing after the list should have changed. Comparing the outputs with the model on every cycle catches these faults in the cycle they appear, not at the end of a test phase.

// File: rtl/rg_pkg.sv
package rg_pkg;

  typedef enum logic [1:0] {
    TRG_NONE,
    TRG_FIRE,
    TRG_SKIP,
    TRG_HOLD
  } trg_kind_e;

  // counter step that stops at the limit
  function automatic int unsigned sat_incr(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // classify a counter update at the threshold
  function automatic trg_kind_e classify(input logic at_lim, input logic listed, input logic busy);
    if (!at_lim) return TRG_NONE;
    if (listed) return TRG_SKIP;
    if (busy) return TRG_HOLD;
    return TRG_FIRE;
  endfunction

endpackage

// File: rtl/rg_key_file.sv
module rg_key_file #(
  parameter int NUM_BANKS = 32,
  parameter int ROW_W = 10,
  parameter int BANK_W = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [BANK_W-1:0]          wr_bank,
  input  logic [ROW_W-1:0]           wr_val,
  input  logic                       act_valid,
  input  logic [BANK_W-1:0]          act_bank,
  input  logic [ROW_W-1:0]           act_row,
  output logic [ROW_W-1:0]           act_gang,
  input  logic [ROW_W-1:0]           req_gang,
  output logic [NUM_BANKS*ROW_W-1:0] req_rows
);

  localparam int FLAT_W = NUM_BANKS * ROW_W;

  logic [ROW_W-1:0]  key_q [NUM_BANKS];
  logic              locked_q;
  logic [FLAT_W-1:0] key_flat;
  logic              wr_ok;

  function automatic logic [ROW_W-1:0] scramble(input logic [ROW_W-1:0] a, input logic [ROW_W-1:0] k);
    return a ^ k;
  endfunction

  assign wr_ok = wr_en && !locked_q && !act_valid &&
                 ({1'b0, wr_bank} < (BANK_W+1)'(NUM_BANKS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      for (int i = 0; i < NUM_BANKS; i++) key_q[i] <= '0;
    end else begin
      if (act_valid) locked_q <= 1'b1;
      if (wr_ok) key_q[wr_bank] <= wr_val;
    end
  end

  assign act_gang = scramble(act_row, key_q[act_bank]);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign key_flat[b*ROW_W +: ROW_W] = key_q[b];
    assign req_rows[b*ROW_W +: ROW_W] = scramble(req_gang, key_q[b]);
  end

  AST_KEYS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) locked_q |=> $stable(key_flat)); // R10

endmodule

// File: rtl/rg_gang_counters.sv
module rg_gang_counters #(
  parameter int ROW_W = 10,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_cnt,
  input  logic             wr_en,
  input  logic [ROW_W-1:0] wr_idx,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             clr_en,
  input  logic [ROW_W-1:0] clr_idx
);

  localparam int DEPTH = 1 << ROW_W;

  logic [CNT_W-1:0] cnt_q [DEPTH];
  logic             same_slot;
  logic             chk_clr_q;
  logic [ROW_W-1:0] chk_idx_q;

  assign same_slot = wr_en && clr_en && (wr_idx == clr_idx);
  assign rd_cnt = cnt_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cnt_q[i] <= '0;
    end else begin
      if (wr_en) cnt_q[wr_idx] <= same_slot ? CNT_W'(1) : wr_val;
      if (clr_en && !same_slot) cnt_q[clr_idx] <= '0;
    end
  end

  // observation registers for the clear check
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_clr_q <= 1'b0;
      chk_idx_q <= '0;
    end else begin
      chk_clr_q <= clr_en && !same_slot;
      chk_idx_q <= clr_idx;
    end
  end

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n) chk_clr_q |-> (cnt_q[chk_idx_q] == '0)); // R6

endmodule

// File: rtl/rg_recent_list.sv
module rg_recent_list #(
  parameter int ROW_W = 10,
  parameter int DEPTH = 4,
  parameter int WINDOW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [ROW_W-1:0] push_gang,
  input  logic             tick,
  input  logic [ROW_W-1:0] look_gang,
  output logic             hit
);

  localparam int AGE_W = $clog2(WINDOW + 1);

  logic [ROW_W-1:0] gang_q [DEPTH];
  logic [AGE_W-1:0] age_q  [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [AGE_W-1:0] age_a  [DEPTH];
  logic [DEPTH-1:0] vld_a;
  logic [ROW_W-1:0] gang_n [DEPTH];
  logic [AGE_W-1:0] age_n  [DEPTH];
  logic [DEPTH-1:0] vld_n;
  logic [DEPTH-1:0] match;

  function automatic logic expires(input logic [AGE_W-1:0] age, input logic t);
    return t && (age == AGE_W'(WINDOW - 1));
  endfunction

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      vld_a[i] = vld_q[i] && !expires(age_q[i], tick);
      age_a[i] = tick ? age_q[i] + AGE_W'(1) : age_q[i];
    end
    if (push) begin
      gang_n[0] = push_gang;
      age_n[0]  = '0;
      vld_n[0]  = 1'b1;
      for (int i = 1; i < DEPTH; i++) begin
        gang_n[i] = gang_q[i-1];
        age_n[i]  = age_a[i-1];
        vld_n[i]  = vld_a[i-1];
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        gang_n[i] = gang_q[i];
        age_n[i]  = age_a[i];
        vld_n[i]  = vld_a[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        gang_q[i] <= '0;
        age_q[i]  <= '0;
      end
    end else begin
      vld_q <= vld_n;
      for (int i = 0; i < DEPTH; i++) begin
        gang_q[i] <= gang_n[i];
        age_q[i]  <= age_n[i];
      end
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = vld_q[i] && (gang_q[i] == look_gang);
    AST_AGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n) vld_q[i] |-> (age_q[i] < AGE_W'(WINDOW))); // R9
  end

  assign hit = |match;

  AST_PUSH_LANDS: assert property (@(posedge clk) disable iff (!rst_n) push |=> (vld_q[0] && gang_q[0] == $past(push_gang))); // R8

endmodule

// File: rtl/rg_gang_tracker.sv
module rg_gang_tracker import rg_pkg::*; #(
  parameter int NUM_BANKS = 32,
  parameter int ROW_W = 10,
  parameter int THRESH = 250,
  parameter int RQ_DEPTH = 4,
  parameter int RQ_WINDOW = 2,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       key_we,
  input  logic [BANK_W-1:0]          key_bank,
  input  logic [ROW_W-1:0]           key_val,
  input  logic                       act_valid,
  input  logic [BANK_W-1:0]          act_bank,
  input  logic [ROW_W-1:0]           act_row,
  input  logic                       refi_tick,
  output logic                       mit_valid,
  input  logic                       mit_ready,
  output logic [ROW_W-1:0]           mit_gang,
  output logic [NUM_BANKS*ROW_W-1:0] mit_rows
);

  localparam int CNT_W = $clog2(THRESH + 1);

  logic [ROW_W-1:0] act_gang;
  logic [CNT_W-1:0] cur_cnt;
  logic [CNT_W-1:0] next_cnt;
  logic [CNT_W-1:0] wr_val;
  logic             at_lim;
  logic             listed;
  logic             accept;
  trg_kind_e        kind;
  logic             trig_fire;
  logic             trig_skip;
  logic             trig_hold;

  rg_key_file #(
    .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .BANK_W(BANK_W)
  ) i_keys (
    .clk(clk), .rst_n(rst_n),
    .wr_en(key_we), .wr_bank(key_bank), .wr_val(key_val),
    .act_valid(act_valid), .act_bank(act_bank), .act_row(act_row),
    .act_gang(act_gang), .req_gang(mit_gang), .req_rows(mit_rows)
  );

  rg_gang_counters #(
    .ROW_W(ROW_W), .CNT_W(CNT_W)
  ) i_counters (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(act_gang), .rd_cnt(cur_cnt),
    .wr_en(act_valid), .wr_idx(act_gang), .wr_val(wr_val),
    .clr_en(accept), .clr_idx(mit_gang)
  );

  rg_recent_list #(
    .ROW_W(ROW_W), .DEPTH(RQ_DEPTH), .WINDOW(RQ_WINDOW)
  ) i_recent (
    .clk(clk), .rst_n(rst_n),
    .push(accept), .push_gang(mit_gang), .tick(refi_tick),
    .look_gang(act_gang), .hit(listed)
  );

  assign accept    = mit_valid && mit_ready;
  assign next_cnt  = CNT_W'(sat_incr(int'(unsigned'(cur_cnt)), THRESH));
  assign at_lim    = act_valid && (next_cnt == CNT_W'(THRESH));
  assign kind      = classify(at_lim, listed, mit_valid);
  assign trig_fire = (kind == TRG_FIRE);
  assign trig_skip = (kind == TRG_SKIP);
  assign trig_hold = (kind == TRG_HOLD);
  assign wr_val    = trig_skip ? '0 : next_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mit_valid <= 1'b0;
      mit_gang  <= '0;
    end else begin
      if (accept) mit_valid <= 1'b0;
      if (trig_fire) begin
        mit_valid <= 1'b1;
        mit_gang  <= act_gang;
      end
    end
  end

  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (mit_valid && !mit_ready) |=> (mit_valid && $stable(mit_gang))); // R5
  AST_REQ_FROM_ACT: assert property (@(posedge clk) disable iff (!rst_n) $rose(mit_valid) |-> $past(act_valid)); // R3
  AST_NO_LISTED_FIRE: assert property (@(posedge clk) disable iff (!rst_n) $rose(mit_valid) |-> !$past(listed)); // R8
  AST_HOLD_KEEPS_REQ: assert property (@(posedge clk) disable iff (!rst_n) (trig_hold && !mit_ready) |=> (mit_gang == $past(mit_gang))); // R7

endmodule

// File: tb/test_rg_gang_tracker.sv
module test_rg_gang_tracker;

  localparam int NB = 32;
  localparam int RW = 10;
  localparam int BW = 5;
  localparam int TH = 250;
  localparam int QD = 4;
  localparam int QW = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           key_we = 1'b0;
  logic [BW-1:0]  key_bank = '0;
  logic [RW-1:0]  key_val = '0;
  logic           act_valid = 1'b0;
  logic [BW-1:0]  act_bank = '0;
  logic [RW-1:0]  act_row = '0;
  logic           refi_tick = 1'b0;
  logic           mit_valid;
  logic           mit_ready = 1'b0;
  logic [RW-1:0]  mit_gang;
  logic [NB*RW-1:0] mit_rows;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model state
  int m_cnt[int];
  int m_key[NB];
  bit m_locked = 0;
  bit m_pv = 0;
  int m_pg = 0;
  int q_g[$];
  int q_a[$];

  rg_gang_tracker i_rg_gang_tracker (
    .clk(clk), .rst_n(rst_n),
    .key_we(key_we), .key_bank(key_bank), .key_val(key_val),
    .act_valid(act_valid), .act_bank(act_bank), .act_row(act_row),
    .refi_tick(refi_tick),
    .mit_valid(mit_valid), .mit_ready(mit_ready),
    .mit_gang(mit_gang), .mit_rows(mit_rows)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int row_field(input int b);
    return int'(mit_rows[b*RW +: RW]);
  endfunction

  // one clock: drive, advance the model, compare
  task automatic cyc(input bit av, input int ab, input int ar, input bit rdy, input bit tk,
                     input bit kwe = 0, input int kb = 0, input int kv = 0);
    bit acc;
    bit hit;
    bit fire;
    int idx;
    int n;
    int acc_g;
    @(negedge clk);
    act_valid = av; act_bank = BW'(ab); act_row = RW'(ar);
    mit_ready = rdy; refi_tick = tk;
    key_we = kwe; key_bank = BW'(kb); key_val = RW'(kv);
    acc = m_pv && rdy;
    acc_g = m_pg;
    idx = ar ^ m_key[ab];
    hit = 0;
    foreach (q_g[i]) if (q_g[i] == idx) hit = 1;
    fire = 0;
    if (av) begin
      n = m_cnt.exists(idx) ? m_cnt[idx] : 0;
      n = (n >= TH) ? TH : n + 1;
      if (n == TH) begin
        if (hit) n = 0;
        else if (!m_pv) fire = 1;
      end
      m_cnt[idx] = n;
    end
    if (acc) m_cnt[acc_g] = (av && idx == acc_g) ? 1 : 0;
    if (acc) m_pv = 0;
    if (fire) begin
      m_pv = 1;
      m_pg = idx;
    end
    if (tk) begin
      for (int i = q_a.size() - 1; i >= 0; i--) begin
        q_a[i] = q_a[i] + 1;
        if (q_a[i] == QW) begin
          q_a.delete(i);
          q_g.delete(i);
        end
      end
    end
    if (acc) begin
      q_g.push_front(acc_g);
      q_a.push_front(0);
      if (q_g.size() > QD) begin
        void'(q_g.pop_back());
        void'(q_a.pop_back());
      end
    end
    if (kwe && !m_locked && !av) m_key[kb] = kv;
    if (av) m_locked = 1;
    @(posedge clk);
    #1;
    chk(mit_valid == m_pv, "R3", "model valid", int'(mit_valid), int'(m_pv));
    if (m_pv) begin
      chk(int'(mit_gang) == m_pg, "R5", "model gang", int'(mit_gang), m_pg);
      for (int b = 0; b < NB; b++)
        if (row_field(b) != (m_pg ^ m_key[b]))
          chk(0, "R4", "model row", row_field(b), m_pg ^ m_key[b]);
    end
    act_valid = 0; key_we = 0; refi_tick = 0;
  endtask

  task automatic hammer(input int g, input int cnt, input bit rdy = 0);
    for (int i = 0; i < cnt; i++) begin
      int b = i % NB;
      cyc(1, b, g ^ m_key[b], rdy, 0);
    end
  endtask

  task automatic take();
    cyc(0, 0, 0, 1, 0);
  endtask

  task automatic tick();
    cyc(0, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", checks, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int g;
    int h;
    int k;
    int old3;
    for (int b = 0; b < NB; b++) m_key[b] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(mit_valid == 1'b0, "R1", "valid after reset", int'(mit_valid), 0);
    chk(mit_gang == '0, "R1", "gang after reset", int'(mit_gang), 0);

    // R10 key loading before the first activation
    for (int b = 0; b < NB; b++) cyc(0, 0, 0, 0, 0, 1, b, (b * 397 + 123) & 1023);

    g = 5;
    // R2 R3: activations spread across banks share gang g
    hammer(g, TH - 1);
    chk(mit_valid == 1'b0, "R3", "no request one short", int'(mit_valid), 0);
    hammer(g, 1);
    chk(mit_valid == 1'b1, "R3", "request at threshold", int'(mit_valid), 1);
    chk(int'(mit_gang) == g, "R2", "shared gang", int'(mit_gang), g);
    chk(row_field(7) == (g ^ ((7 * 397 + 123) & 1023)), "R4", "bank 7 row", row_field(7), g ^ ((7 * 397 + 123) & 1023));
    chk(row_field(0) == (g ^ 123), "R10", "key 0 loaded", row_field(0), g ^ 123);

    // R5 hold without ready
    repeat (3) cyc(0, 0, 0, 0, 0);
    chk(mit_valid && int'(mit_gang) == g, "R5", "held gang", int'(mit_gang), g);

    // R7 another gang reaches threshold while busy
    h = 700;
    hammer(h, TH);
    chk(int'(mit_gang) == g, "R7", "blocked trigger", int'(mit_gang), g);
    take();
    chk(mit_valid == 1'b0, "R5", "drop after accept", int'(mit_valid), 0);
    hammer(h, 1);
    chk(mit_valid && int'(mit_gang) == h, "R7", "retry fires", int'(mit_gang), h);
    take();

    // R8 listed gang is skipped
    hammer(g, TH);
    chk(mit_valid == 1'b0, "R8", "listed gang skipped", int'(mit_valid), 0);

    // R9 one tick is not enough, two expire
    tick();
    hammer(g, TH);
    chk(mit_valid == 1'b0, "R9", "still listed after one tick", int'(mit_valid), 0);
    tick();
    hammer(g, TH);
    chk(mit_valid && int'(mit_gang) == g, "R9", "expired entry", int'(mit_gang), g);

    // R6 activation in the acceptance cycle leaves count 1
    cyc(1, 0, g ^ m_key[0], 1, 0);
    tick();
    tick();
    hammer(g, TH - 2);
    chk(mit_valid == 1'b0, "R6", "count restarted at 1", int'(mit_valid), 0);
    hammer(g, 1);
    chk(mit_valid && int'(mit_gang) == g, "R6", "fires after restart", int'(mit_gang), g);
    take();
    tick();
    tick();

    // R10 key write after lock is ignored
    old3 = m_key[3];
    cyc(0, 0, 0, 0, 0, 1, 3, old3 ^ 255);
    k = 300;
    hammer(k, TH);
    chk(mit_valid && row_field(3) == (k ^ old3), "R10", "late key ignored", row_field(3), k ^ old3);
    take();
    tick();
    tick();

    // R9 list depth: oldest pushed out
    for (int j = 40; j < 45; j++) begin
      hammer(j, TH);
      take();
    end
    hammer(40, TH);
    chk(mit_valid && int'(mit_gang) == 40, "R9", "oldest pushed out", int'(mit_gang), 40);
    take();
    hammer(43, TH);
    chk(mit_valid == 1'b0, "R9", "kept entry skips", int'(mit_valid), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule